// File: doc/BRIEF.md
# Threshold Resource Event Generator

This block compares occupancy counts against configured thresholds. Each count belongs to a buffer pool and is maintained elsewhere. Three kinds of threshold are watched. The first is a single descriptor-type threshold on one count. The second is a total threshold on the overall count. The third is a set of per-pool thresholds, one for each pool count. A count that rises from below its threshold to at or above it is a crossing. An enabled crossing becomes a resource event, and events leave the block through a valid/ready handshake towards a receive-queue consumer.

Software programs the block through a small write/read register port. A control word holds the following bits:
- a global interface enable that gates all event generation,
- a limit-mode bit,
- one enable bit for each source kind.

In limit mode a source reports only its first crossing. The block then clears that source's enable bit itself, so software must set the bit again before that source can report another crossing. Crossings that occur while a source is disarmed are lost. When several sources cross in the same cycle, their events wait in a pending set and leave one per handshake in a fixed order.

Top module: `thr_event_gen`

## Requirements
- R1: After reset `ev_valid` is 0, the control word (address 0) reads 0, and every threshold register reads all ones.
- R2: When a count goes from below its threshold to at or above it, exactly one event is sent. The event carries a source code in `ev_src` (0 = descriptor-type, 1 = total, 2 = pool) and a pool index in `ev_pool`, which is 0 for non-pool sources. A count that stays at or above its threshold sends nothing further.
- R3: While control bit 0 (interface enable) is 0, no event is loaded and crossings are discarded; setting the bit later does not report them.
- R4: A crossing of a source whose enable bit is 0 sends no event. The enable bits are control bit 2 (descriptor-type), bit 3 (total) and bit 4 (pool, shared by all pools).
- R5: With control bit 1 (limit mode) set, an enabled crossing sends one event and the source's enable bit reads back as 0.
- R6: In limit mode, later crossings of a disarmed source are lost. After software writes the enable bit to 1 again, the next crossing sends an event.
- R7: Crossings pending together leave one per handshake in this order: total first, then pools from the lowest index up, then descriptor-type.
- R8: While `ev_valid` is 1 and `ev_ready` is 0, `ev_valid`, `ev_src` and `ev_pool` hold their values.
- R9: A control write that sets an enable bit wins over an automatic clear of that bit in the same cycle.
- R10: With limit mode off, an enable bit remains set after its source sends an event.
- R11: Registers sit at these addresses: 0 control, 1 descriptor-type threshold, 2 total threshold, 3+p pool p threshold. `reg_rdata` shows the register at `reg_addr` one cycle after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address for write and read |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Registered read data for `reg_addr` |
| dtype_count | input | CW | Descriptor-type occupancy count |
| total_count | input | CW | Total occupancy count |
| pool_count | input | NUM_POOLS*CW | Per-pool occupancy counts, pool p at bits p*CW |
| ev_valid | output | 1 | Event available |
| ev_ready | input | 1 | Consumer accepts event |
| ev_src | output | 2 | Event source code |
| ev_pool | output | PW | Pool index of a pool event |

## Verification
In limit mode, the automatic clear of a source's enable bit and a software write to the control word can land on the same clock edge. The bench provokes this by raising the total count over its threshold in the same cycle that it writes the control word with the total enable set. It then reads the control word back and expects the enable bit still set, and it compares this against a run without the write, where the bit reads back cleared. Handshake back-pressure can also meet new crossings: all four counters cross together while `ev_ready` is low, and the bench judges the held payload and the exact order in which the events leave.

// File: rtl/thr_evt_pkg.sv
package thr_evt_pkg;
  typedef enum logic [1:0] {
    SRC_DTYPE = 2'd0,
    SRC_TOTAL = 2'd1,
    SRC_POOL  = 2'd2
  } src_e;

  // control word bit positions
  localparam int CTL_IFACE    = 0;
  localparam int CTL_LIMIT    = 1;
  localparam int CTL_EN_BASE  = 2;  // enables: +0 dtype, +1 total, +2 pool
  localparam int CTL_WIDTH    = 5;

  // register addresses
  localparam int ADR_CTRL  = 0;
  localparam int ADR_DTHR  = 1;
  localparam int ADR_TTHR  = 2;
  localparam int ADR_PTHR0 = 3;
endpackage

// File: rtl/thr_cross_det.sv
module thr_cross_det #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] count,
  input  logic [CW-1:0] thr,
  output logic          rise
);
  logic above;
  logic above_q;

  assign above = (count >= thr);

  always_ff @(posedge clk) begin
    if (rst) above_q <= 1'b1;
    else     above_q <= above;
  end

  assign rise = above & ~above_q;
endmodule

// File: rtl/thr_cfg_regs.sv
module thr_cfg_regs
  import thr_evt_pkg::*;
#(
  parameter int NUM_POOLS = 8,
  parameter int CW        = 12,
  parameter int ADDR_W    = 4,
  parameter int DW        = 12
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    we,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [DW-1:0]           wdata,
  input  logic [2:0]              en_clr,
  output logic                    wr_ctrl,
  output logic                    iface_en,
  output logic                    limit_mode,
  output logic [2:0]              en_q,
  output logic [CW-1:0]           dthr,
  output logic [CW-1:0]           tthr,
  output logic [NUM_POOLS*CW-1:0] pthr,
  output logic [DW-1:0]           rdata
);
  logic [CW-1:0] pthr_q [NUM_POOLS];
  logic [DW-1:0] rd_mux;

  assign wr_ctrl = we && (addr == ADDR_W'(ADR_CTRL));

  always_ff @(posedge clk) begin
    if (rst) begin
      iface_en   <= 1'b0;
      limit_mode <= 1'b0;
      en_q       <= 3'b000;
      dthr       <= '1;
      tthr       <= '1;
      for (int p = 0; p < NUM_POOLS; p++) pthr_q[p] <= '1;
    end else begin
      if (wr_ctrl) begin
        iface_en   <= wdata[CTL_IFACE];
        limit_mode <= wdata[CTL_LIMIT];
        en_q       <= wdata[CTL_EN_BASE +: 3];
      end else begin
        en_q <= en_q & ~en_clr;
      end
      if (we && addr == ADDR_W'(ADR_DTHR)) dthr <= wdata[CW-1:0];
      if (we && addr == ADDR_W'(ADR_TTHR)) tthr <= wdata[CW-1:0];
      for (int p = 0; p < NUM_POOLS; p++) begin
        if (we && addr == ADDR_W'(ADR_PTHR0 + p)) pthr_q[p] <= wdata[CW-1:0];
      end
    end
  end

  for (genvar g = 0; g < NUM_POOLS; g++) begin : g_pflat
    assign pthr[g*CW +: CW] = pthr_q[g];
  end

  always_comb begin
    rd_mux = '0;
    if (addr == ADDR_W'(ADR_CTRL)) begin
      rd_mux[CTL_IFACE]        = iface_en;
      rd_mux[CTL_LIMIT]        = limit_mode;
      rd_mux[CTL_EN_BASE +: 3] = en_q;
    end else if (addr == ADDR_W'(ADR_DTHR)) begin
      rd_mux = DW'(dthr);
    end else if (addr == ADDR_W'(ADR_TTHR)) begin
      rd_mux = DW'(tthr);
    end else begin
      for (int p = 0; p < NUM_POOLS; p++) begin
        if (addr == ADDR_W'(ADR_PTHR0 + p)) rd_mux = DW'(pthr_q[p]);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_mux;
  end
endmodule

// File: rtl/thr_event_arb.sv
module thr_event_arb
  import thr_evt_pkg::*;
#(
  parameter int NUM_POOLS = 8,
  parameter int PW        = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 iface_en,
  input  logic                 req_dtype,
  input  logic                 req_total,
  input  logic [NUM_POOLS-1:0] req_pool,
  input  logic                 ev_ready,
  output logic                 ev_valid,
  output logic [1:0]           ev_src,
  output logic [PW-1:0]        ev_pool
);
  logic                 pend_d, pend_t;
  logic [NUM_POOLS-1:0] pend_p;
  logic                 load;
  logic                 take_d, take_t;
  logic [NUM_POOLS-1:0] take_p, low_p;
  src_e                 sel_src;
  logic [PW-1:0]        sel_pool;

  assign load  = iface_en && (!ev_valid || ev_ready) && (pend_d || pend_t || (|pend_p));
  assign low_p = pend_p & (~pend_p + 1'b1);

  always_comb begin
    take_d   = 1'b0;
    take_t   = 1'b0;
    take_p   = '0;
    sel_src  = SRC_DTYPE;
    sel_pool = '0;
    if (pend_t) begin
      take_t  = load;
      sel_src = SRC_TOTAL;
    end else if (|pend_p) begin
      take_p  = load ? low_p : '0;
      sel_src = SRC_POOL;
      for (int p = NUM_POOLS - 1; p >= 0; p--) begin
        if (pend_p[p]) sel_pool = PW'(p);
      end
    end else if (pend_d) begin
      take_d  = load;
      sel_src = SRC_DTYPE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !iface_en) begin
      pend_d <= 1'b0;
      pend_t <= 1'b0;
      pend_p <= '0;
    end else begin
      pend_d <= (pend_d & ~take_d) | req_dtype;
      pend_t <= (pend_t & ~take_t) | req_total;
      pend_p <= (pend_p & ~take_p) | req_pool;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ev_valid <= 1'b0;
      ev_src   <= 2'd0;
      ev_pool  <= '0;
    end else if (load) begin
      ev_valid <= 1'b1;
      ev_src   <= sel_src;
      ev_pool  <= sel_pool;
    end else if (ev_ready) begin
      ev_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/thr_event_gen.sv
module thr_event_gen
  import thr_evt_pkg::*;
#(
  parameter int  NUM_POOLS = 8,
  parameter int  CW        = 12,
  localparam int ADDR_W    = $clog2(NUM_POOLS + 3),
  localparam int DW        = (CW > CTL_WIDTH) ? CW : CTL_WIDTH,
  localparam int PW        = (NUM_POOLS > 1) ? $clog2(NUM_POOLS) : 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    reg_we,
  input  logic [ADDR_W-1:0]       reg_addr,
  input  logic [DW-1:0]           reg_wdata,
  output logic [DW-1:0]           reg_rdata,
  input  logic [CW-1:0]           dtype_count,
  input  logic [CW-1:0]           total_count,
  input  logic [NUM_POOLS*CW-1:0] pool_count,
  output logic                    ev_valid,
  input  logic                    ev_ready,
  output logic [1:0]              ev_src,
  output logic [PW-1:0]           ev_pool
);
  logic                    wr_ctrl, iface_en, limit_mode;
  logic [2:0]              en_q, src_req, en_clr;
  logic [CW-1:0]           dthr, tthr;
  logic [NUM_POOLS*CW-1:0] pthr;
  logic                    rise_d, rise_t;
  logic [NUM_POOLS-1:0]    rise_p, req_p;
  logic                    req_d, req_t;

  thr_cfg_regs #(.NUM_POOLS(NUM_POOLS), .CW(CW), .ADDR_W(ADDR_W), .DW(DW)) regs_i (
    .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .en_clr(en_clr), .wr_ctrl(wr_ctrl), .iface_en(iface_en),
    .limit_mode(limit_mode), .en_q(en_q), .dthr(dthr), .tthr(tthr),
    .pthr(pthr), .rdata(reg_rdata)
  );

  thr_cross_det #(.CW(CW)) det_d_i (
    .clk(clk), .rst(rst), .count(dtype_count), .thr(dthr), .rise(rise_d)
  );
  thr_cross_det #(.CW(CW)) det_t_i (
    .clk(clk), .rst(rst), .count(total_count), .thr(tthr), .rise(rise_t)
  );
  for (genvar g = 0; g < NUM_POOLS; g++) begin : g_pool
    thr_cross_det #(.CW(CW)) det_p_i (
      .clk(clk), .rst(rst), .count(pool_count[g*CW +: CW]),
      .thr(pthr[g*CW +: CW]), .rise(rise_p[g])
    );
  end

  assign req_d   = rise_d & en_q[0] & iface_en;
  assign req_t   = rise_t & en_q[1] & iface_en;
  assign req_p   = rise_p & {NUM_POOLS{en_q[2] & iface_en}};
  assign src_req = {|req_p, req_t, req_d};
  assign en_clr  = src_req & {3{limit_mode}};

  thr_event_arb #(.NUM_POOLS(NUM_POOLS), .PW(PW)) arb_i (
    .clk(clk), .rst(rst), .iface_en(iface_en), .req_dtype(req_d),
    .req_total(req_t), .req_pool(req_p), .ev_ready(ev_ready),
    .ev_valid(ev_valid), .ev_src(ev_src), .ev_pool(ev_pool)
  );
endmodule

// File: rtl/thr_event_gen_chk.sv
module thr_event_gen_chk #(
  parameter int PW = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          iface_en,
  input logic          limit_mode,
  input logic [2:0]    en_q,
  input logic [2:0]    src_req,
  input logic          wr_ctrl,
  input logic          wr_en_total,
  input logic          ev_valid,
  input logic          ev_ready,
  input logic [1:0]    ev_src,
  input logic [PW-1:0] ev_pool
);
  AST_SRC_LEGAL: assert property (@(posedge clk) disable iff (rst)
    ev_valid |-> ev_src != 2'd3); // R2
  AST_POOL_IDX_ZERO: assert property (@(posedge clk) disable iff (rst)
    (ev_valid && ev_src != 2'd2) |-> ev_pool == '0); // R2
  AST_NO_LOAD_OFF: assert property (@(posedge clk) disable iff (rst)
    (!iface_en && !ev_valid) |=> !ev_valid); // R3
  AST_LIMIT_AUTOCLR: assert property (@(posedge clk) disable iff (rst)
    (limit_mode && src_req[1] && !wr_ctrl) |=> !en_q[1]); // R5
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
    (ev_valid && !ev_ready) |=> (ev_valid && $stable(ev_src) && $stable(ev_pool))); // R8
  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (rst)
    (wr_ctrl && wr_en_total) |=> en_q[1]); // R9
  AST_EN_KEEP: assert property (@(posedge clk) disable iff (rst)
    (!limit_mode && en_q[1] && !wr_ctrl) |=> en_q[1]); // R10
endmodule

bind thr_event_gen thr_event_gen_chk #(.PW(PW)) chk_i (
  .clk(clk), .rst(rst), .iface_en(iface_en), .limit_mode(limit_mode),
  .en_q(en_q), .src_req(src_req), .wr_ctrl(wr_ctrl),
  .wr_en_total(reg_wdata[3]), .ev_valid(ev_valid), .ev_ready(ev_ready),
  .ev_src(ev_src), .ev_pool(ev_pool)
);

// File: tb/thr_event_gen_tb_top.sv
`timescale 1ns/1ps
module thr_event_gen_tb_top;
  localparam int NP = 2;
  localparam int CW = 4;
  localparam int AW = 3;
  localparam int DW = 5;
  localparam int PW = 1;
  localparam int C_IF = 1, C_LIM = 2, C_ED = 4, C_ET = 8, C_EP = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          reg_we = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic [CW-1:0] dtype_count = '0;
  logic [CW-1:0] total_count = '0;
  logic [NP*CW-1:0] pool_count = '0;
  logic          ev_valid;
  logic          ev_ready = 1'b1;
  logic [1:0]    ev_src;
  logic [PW-1:0] ev_pool;

  int n_chk = 0;
  int n_bad = 0;
  int nlog = 0;
  logic [1:0] log_src [16];
  logic [PW-1:0] log_pool [16];
  bit done = 0;

  always #2ns clk = ~clk;

  thr_event_gen #(.NUM_POOLS(NP), .CW(CW)) dut_i (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dtype_count(dtype_count),
    .total_count(total_count), .pool_count(pool_count), .ev_valid(ev_valid),
    .ev_ready(ev_ready), .ev_src(ev_src), .ev_pool(ev_pool)
  );

  always @(negedge clk) begin
    if (ev_valid && ev_ready) begin
      if (nlog < 16) begin
        log_src[nlog]  = ev_src;
        log_pool[nlog] = ev_pool;
      end
      nlog = nlog + 1;
    end
  end

  task automatic tick();
    @(posedge clk);
    #1ns;
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    reg_we = 1'b1; reg_addr = AW'(a); reg_wdata = DW'(d);
    tick();
    reg_we = 1'b0;
  endtask

  task automatic rd(input int a, output int v);
    reg_addr = AW'(a);
    tick();
    v = int'(reg_rdata);
  endtask

  task automatic set_cnt(input int sel, input int p, input int v);
    if (sel == 0)      dtype_count = CW'(v);
    else if (sel == 1) total_count = CW'(v);
    else               pool_count[p*CW +: CW] = CW'(v);
  endtask

  task automatic ramp(input int sel, input int p);
    for (int v = 0; v < 16; v++) begin
      set_cnt(sel, p, v);
      tick();
    end
    repeat (4) tick();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog act=0 exp=1");
    finish_run();
  end

  initial begin
    int v;
    repeat (3) tick();
    rst = 1'b0;
    tick();

    // R1: reset state
    chk(ev_valid == 1'b0, "R1 ev_valid", int'(ev_valid), 0);
    rd(0, v); chk(v == 0, "R1 ctrl", v, 0);
    for (int a = 1; a < 3 + NP; a++) begin
      rd(a, v); chk(v == 15, "R1/R11 threshold", v, 15);
    end

    // R2/R11: sweep every threshold for every source
    wr(0, C_IF | C_ED | C_ET | C_EP);
    for (int sel = 0; sel < 3; sel++) begin
      for (int p = 0; p < ((sel == 2) ? NP : 1); p++) begin
        for (int t = 1; t < 16; t++) begin
          set_cnt(sel, p, 0);
          repeat (2) tick();
          wr((sel == 2) ? 3 + p : ((sel == 0) ? 1 : 2), t);
          rd((sel == 2) ? 3 + p : ((sel == 0) ? 1 : 2), v);
          chk(v == t, "R11 readback", v, t);
          nlog = 0;
          ramp(sel, p);
          chk(nlog == 1, "R2 one event per crossing", nlog, 1);
          chk(log_src[0] == 2'(sel), "R2 source code", int'(log_src[0]), sel);
          chk(int'(log_pool[0]) == ((sel == 2) ? p : 0), "R2 pool index",
              int'(log_pool[0]), (sel == 2) ? p : 0);
        end
      end
    end

    // R3: interface disabled, crossings discarded
    set_cnt(1, 0, 0); wr(2, 8); repeat (2) tick();
    wr(0, C_ED | C_ET | C_EP);
    nlog = 0;
    ramp(1, 0);
    wr(0, C_IF | C_ED | C_ET | C_EP);
    repeat (6) tick();
    chk(nlog == 0, "R3 no event while disabled", nlog, 0);

    // R4: source disabled
    set_cnt(1, 0, 0); repeat (2) tick();
    wr(0, C_IF | C_ED | C_EP);
    nlog = 0;
    ramp(1, 0);
    chk(nlog == 0, "R4 disabled source", nlog, 0);

    // R5/R6: limit mode
    set_cnt(1, 0, 0); repeat (2) tick();
    wr(0, C_IF | C_LIM | C_ET);
    nlog = 0;
    ramp(1, 0);
    chk(nlog == 1, "R5 first event", nlog, 1);
    rd(0, v); chk(v == (C_IF | C_LIM), "R5 enable auto-cleared", v, C_IF | C_LIM);
    set_cnt(1, 0, 0); repeat (2) tick();
    nlog = 0;
    ramp(1, 0);
    chk(nlog == 0, "R6 crossing lost while disarmed", nlog, 0);
    set_cnt(1, 0, 0); repeat (2) tick();
    wr(0, C_IF | C_LIM | C_ET);
    nlog = 0;
    ramp(1, 0);
    chk(nlog == 1, "R6 re-armed event", nlog, 1);

    // R9: write with enable set in the cycle of auto-clear
    set_cnt(1, 0, 0); repeat (2) tick();
    wr(0, C_IF | C_LIM | C_ET);
    repeat (2) tick();
    nlog = 0;
    total_count = 4'd15;
    reg_we = 1'b1; reg_addr = 3'd0; reg_wdata = DW'(C_IF | C_LIM | C_ET);
    tick();
    reg_we = 1'b0;
    repeat (4) tick();
    rd(0, v); chk(v == (C_IF | C_LIM | C_ET), "R9 write wins over auto-clear", v, C_IF | C_LIM | C_ET);
    chk(nlog == 1, "R9 event sent", nlog, 1);

    // R10: non-limit keeps enable
    set_cnt(1, 0, 0); repeat (2) tick();
    wr(0, C_IF | C_ET);
    nlog = 0;
    ramp(1, 0);
    rd(0, v); chk(v == (C_IF | C_ET), "R10 enable kept", v, C_IF | C_ET);
    chk(nlog == 1, "R10 event sent", nlog, 1);

    // R7/R8: simultaneous crossings under back-pressure
    wr(0, C_IF | C_ED | C_ET | C_EP);
    for (int s = 0; s < 3; s++) set_cnt(s, 0, 0);
    set_cnt(2, 1, 0);
    for (int a = 1; a < 3 + NP; a++) wr(a, 8);
    repeat (2) tick();
    ev_ready = 1'b0;
    nlog = 0;
    dtype_count = 4'd15; total_count = 4'd15; pool_count = 8'hFF;
    repeat (3) tick();
    for (int k = 0; k < 5; k++) begin
      chk(ev_valid == 1'b1 && ev_src == 2'd1 && ev_pool == 1'b0,
          "R8 held payload", int'({ev_valid, ev_src}), 5);
      tick();
    end
    ev_ready = 1'b1;
    repeat (8) tick();
    chk(nlog == 4, "R7 event count", nlog, 4);
    chk(log_src[0] == 2'd1, "R7 first total", int'(log_src[0]), 1);
    chk(log_src[1] == 2'd2 && log_pool[1] == 1'b0, "R7 second pool0",
        int'({log_src[1], log_pool[1]}), 4);
    chk(log_src[2] == 2'd2 && log_pool[2] == 1'b1, "R7 third pool1",
        int'({log_src[2], log_pool[2]}), 5);
    chk(log_src[3] == 2'd0, "R7 last dtype", int'(log_src[3]), 0);

    finish_run();
  end
endmodule